// File: doc/BRIEF.md
# Real-Time Counter with Periodic Interrupt

The block is a free-running counter that advances on rising edges of one of four slow clock-source inputs. Everything runs in one system clock domain. Each source is synchronised and edge-detected, so one source edge becomes a single-cycle tick. Two optional fixed prescalers can divide the tick stream, one by DIV_A (default 512) and one by DIV_B (default 32). When both are on they run in series.

The counter has a main compare channel and a rollover flag, which share one interrupt line. A separate periodic channel has its own compare value and its own interrupt line. A debug-halt input can freeze the count when freeze is enabled.

Software uses a single 32-bit control word, a status word with write-one-to-clear flags, and a read-only count. Clearing the run bit holds all counting logic in reset. Clock source and prescaler settings can then be changed without a spurious tick.

Top module: `rtc_periodic_counter`

## Requirements
- R1: After rst_n is released, the control, status and count words all read 0, and both interrupt outputs are low.
- R2: The control word (addr 0) reads back exactly the value last written. Bits are given in LSB-0 index:
  - [31] run
  - [30] main interrupt enable
  - [29] freeze enable
  - [28] rollover interrupt enable
  - [27:16] main compare
  - [15] periodic enable
  - [14] periodic interrupt enable
  - [13:12] source select
  - [11] DIV_A prescaler enable
  - [10] DIV_B prescaler enable
  - [9:0] periodic compare
- R3: While run is 0, the prescalers, count, periodic count and all flags are held at zero. This holds even when the select or prescaler fields change. Once run is cleared, the count reads 0 within two cycles.
- R4: With both prescalers off, the count (addr 2) rises by exactly one per rising edge of the selected source: select value n picks src_clk[n].
- R5: The DIV_A enable passes one tick in DIV_A. The DIV_B enable passes one tick in DIV_B. With both enabled, one tick passes in DIV_A*DIV_B.
- R6: Status bit 0 (addr 1) sets on the step that takes the count to a value whose upper 12 bits equal the main compare and whose lower bits are zero.
- R7: Status bit 2 sets on the step from the all-ones count to zero.
- R8: irq_main is high exactly when (status bit 0 AND main interrupt enable) OR (status bit 2 AND rollover interrupt enable).
- R9: With periodic enable set and compare value P, the periodic count advances on each step. It sets status bit 1 every P+1 steps and reloads to zero. irq_per is high exactly when status bit 1 is set and periodic interrupt enable is 1.
- R10: When freeze enable and dbg_halt are both 1, the count holds. Counting resumes from the held value when dbg_halt drops. When freeze enable is 0, dbg_halt has no effect.
- R11: Writing the status word clears each flag whose data bit is 1. Zero bits leave their flag unchanged. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at addr |
| addr | input | 2 | Word select: 0 control, 1 status, 2 count |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational readback of the word at addr |
| src_clk | input | 4 | Slow clock-source inputs |
| dbg_halt | input | 1 | Debug halt request |
| irq_main | output | 1 | Main compare / rollover interrupt request |
| irq_per | output | 1 | Periodic interrupt request |

## Verification
The latencies are as follows:
- A control or status write shows on readback and on the interrupt outputs one cycle after its edge.
- Setting run takes effect two edges after the write edge.
- A source rising edge reaches the count three edges after it happens: two synchroniser stages, then the edge-detect register.

Directed checks never sample right at these transitions. They wait out the pipeline and then measure count differences over fixed windows whose tick count is exact. A behavioural model in the bench steps once per clock with the same latencies. It is compared against rd_data and both interrupt lines at every falling edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int REG_W      = 32;
    localparam int MAIN_CMP_W = 12;
    localparam int PER_CMP_W  = 10;
    localparam int SEL_W      = 2;
    localparam int N_SRC      = 1 << SEL_W;
    localparam int N_FLAG     = 3;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_STAT  = 2'd1;
    localparam logic [1:0] ADDR_COUNT = 2'd2;

    localparam int FL_MAIN = 0;
    localparam int FL_PER  = 1;
    localparam int FL_ROLL = 2;

    // first member lands in bit 31
    typedef struct packed {
        logic                  run;
        logic                  main_ie;
        logic                  frz_en;
        logic                  roll_ie;
        logic [MAIN_CMP_W-1:0] main_cmp;
        logic                  per_en;
        logic                  per_ie;
        logic [SEL_W-1:0]      src_sel;
        logic                  div_a_en;
        logic                  div_b_en;
        logic [PER_CMP_W-1:0]  per_cmp;
    } ctrl_t;
endpackage

// File: rtl/rtc_regs.sv
module rtc_regs
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wr_data,
    output ctrl_t             ctrl,
    output logic              active,
    output logic [N_FLAG-1:0] flag_clr
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  run;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == ADDR_CTRL) begin
            st_d.ctrl = ctrl_t'(wr_data);
        end
        // release of the counting logic lags the run bit by one edge
        st_d.run = st_q.ctrl.run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl     = st_q.ctrl;
    assign active   = st_q.ctrl.run & st_q.run;
    assign flag_clr = (wr_en && addr == ADDR_STAT) ? wr_data[N_FLAG-1:0] : '0;
endmodule

// File: rtl/rtc_tick_src.sv
module rtc_tick_src
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [N_SRC-1:0] src_clk,
    input  logic [SEL_W-1:0] sel,
    output logic             raw_tick
);
    typedef struct packed {
        logic [N_SRC-1:0] s1;
        logic [N_SRC-1:0] s2;
        logic             prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        if (!active) begin
            sy_d = '0;
        end else begin
            sy_d.s1   = src_clk;
            sy_d.s2   = sy_q.s1;
            sy_d.prev = sy_q.s2[sel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign raw_tick = active & sy_q.s2[sel] & ~sy_q.prev;
endmodule

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
    parameter int DIV = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic en,
    input  logic tick_in,
    output logic tick_out
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          wrap;

    always_comb begin
        wrap = (cnt_q == LAST);
        if (!active || !en) begin
            cnt_d = '0;
        end else if (tick_in) begin
            cnt_d = wrap ? '0 : cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
        tick_out = en ? (tick_in & wrap) : tick_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  active,
    input  logic                  tick,
    input  logic                  freeze,
    input  logic [MAIN_CMP_W-1:0] main_cmp,
    input  logic                  per_en,
    input  logic [PER_CMP_W-1:0]  per_cmp,
    input  logic [N_FLAG-1:0]     flag_clr,
    output logic [COUNT_W-1:0]    count,
    output logic [N_FLAG-1:0]     flags
);
    localparam int LOW_W = COUNT_W - MAIN_CMP_W;

    typedef struct packed {
        logic [COUNT_W-1:0]   cnt;
        logic [PER_CMP_W-1:0] per_cnt;
        logic [N_FLAG-1:0]    flags;
    } cnt_t;

    cnt_t cs_d, cs_q;
    logic               step;
    logic [COUNT_W-1:0] cnt_inc;
    logic [N_FLAG-1:0]  set_ev;
    logic               per_hit;

    always_comb begin
        step    = tick & ~freeze;
        cnt_inc = cs_q.cnt + 1'b1;
        per_hit = step & per_en & (cs_q.per_cnt == per_cmp);

        set_ev          = '0;
        set_ev[FL_MAIN] = step
                        & (cnt_inc[COUNT_W-1 -: MAIN_CMP_W] == main_cmp)
                        & (cnt_inc[LOW_W-1:0] == '0);
        set_ev[FL_ROLL] = step & (&cs_q.cnt);
        set_ev[FL_PER]  = per_hit;

        cs_d       = cs_q;
        cs_d.cnt   = step ? cnt_inc : cs_q.cnt;
        if (!per_en) begin
            cs_d.per_cnt = '0;
        end else if (step) begin
            cs_d.per_cnt = per_hit ? '0 : cs_q.per_cnt + 1'b1;
        end
        cs_d.flags = (cs_q.flags & ~flag_clr) | set_ev;

        if (!active) begin
            cs_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign count = cs_q.cnt;
    assign flags = cs_q.flags;
endmodule

// File: rtl/rtc_periodic_counter.sv
module rtc_periodic_counter
    import rtc_pkg::*;
#(
    parameter int COUNT_W = 32,
    parameter int DIV_A   = 512,
    parameter int DIV_B   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    input  logic [3:0]       src_clk,
    input  logic             dbg_halt,
    output logic             irq_main,
    output logic             irq_per
);
    localparam int N_DIV = 2;

    ctrl_t              ctrl;
    logic               active;
    logic [N_FLAG-1:0]  flag_clr;
    logic               raw_tick;
    logic [N_DIV:0]     chain;
    logic [N_DIV-1:0]   div_en;
    logic [COUNT_W-1:0] count;
    logic [N_FLAG-1:0]  flags;

    rtc_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .ctrl     (ctrl),
        .active   (active),
        .flag_clr (flag_clr)
    );

    rtc_tick_src u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .src_clk  (src_clk),
        .sel      (ctrl.src_sel),
        .raw_tick (raw_tick)
    );

    assign chain[0] = raw_tick;
    assign div_en   = {ctrl.div_b_en, ctrl.div_a_en};

    for (genvar g = 0; g < N_DIV; g++) begin : g_div
        localparam int DV = (g == 0) ? DIV_A : DIV_B;
        rtc_prescale #(.DIV(DV)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (active),
            .en       (div_en[g]),
            .tick_in  (chain[g]),
            .tick_out (chain[g+1])
        );
    end

    rtc_counter #(.COUNT_W(COUNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tick     (chain[N_DIV]),
        .freeze   (ctrl.frz_en & dbg_halt),
        .main_cmp (ctrl.main_cmp),
        .per_en   (ctrl.per_en),
        .per_cmp  (ctrl.per_cmp),
        .flag_clr (flag_clr),
        .count    (count),
        .flags    (flags)
    );

    always_comb begin
        case (addr)
            ADDR_CTRL:  rd_data = ctrl;
            ADDR_STAT:  rd_data = {{(REG_W-N_FLAG){1'b0}}, flags};
            ADDR_COUNT: rd_data = 32'(count);
            default:    rd_data = '0;
        endcase
    end

    assign irq_main = (flags[FL_MAIN] & ctrl.main_ie) | (flags[FL_ROLL] & ctrl.roll_ie);
    assign irq_per  = flags[FL_PER] & ctrl.per_ie;
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
    import rtc_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  run,
    input logic                  frz_en,
    input logic                  main_ie,
    input logic                  roll_ie,
    input logic [MAIN_CMP_W-1:0] main_cmp,
    input logic                  active,
    input logic                  dbg_halt,
    input logic [COUNT_W-1:0]    count,
    input logic                  main_flag,
    input logic                  roll_flag,
    input logic                  irq_main
);
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count == '0 && !main_flag && !roll_flag)); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0)); // R4

    AST_MAIN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_flag) |-> (count[COUNT_W-1 -: MAIN_CMP_W] == main_cmp)); // R6

    AST_ROLL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(roll_flag) |-> (count == '0)); // R7

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_main |-> ((main_flag && main_ie) || (roll_flag && roll_ie))); // R8

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && frz_en && dbg_halt) |=> $stable(count)); // R10
endmodule

bind rtc_periodic_counter rtc_checker #(.COUNT_W(COUNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl.run),
    .frz_en    (ctrl.frz_en),
    .main_ie   (ctrl.main_ie),
    .roll_ie   (ctrl.roll_ie),
    .main_cmp  (ctrl.main_cmp),
    .active    (active),
    .dbg_halt  (dbg_halt),
    .count     (count),
    .main_flag (flags[0]),
    .roll_flag (flags[2]),
    .irq_main  (irq_main)
);

// File: tb/tb_rtc_periodic_counter.sv
module tb_rtc_periodic_counter;
    localparam int CW   = 14;
    localparam int DA   = 8;
    localparam int DB   = 4;
    localparam int MOD  = 1 << CW;
    localparam int LOWB = CW - 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd3;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  src_clk = '0;
    logic        dbg_halt = 1'b0;
    logic        irq_main, irq_per;

    int tests = 0;
    int fails = 0;
    int tcnt  = 0;

    rtc_periodic_counter #(.COUNT_W(CW), .DIV_A(DA), .DIV_B(DB)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .src_clk(src_clk), .dbg_halt(dbg_halt),
        .irq_main(irq_main), .irq_per(irq_per)
    );

    always #10 clk = ~clk;

    // source k toggles every 2^k cycles
    always @(posedge clk) begin
        #2;
        tcnt++;
        src_clk = 4'(tcnt);
    end

    // behavioural model
    logic [31:0] m_ctrl = '0;
    logic [3:0]  m_s1 = '0, m_s2 = '0, n_s1, n_s2;
    logic [2:0]  m_flags = '0, n_flags, m_set, m_clr;
    bit m_run = 0, m_prev = 0, n_prev, n_act, n_raw, n_ta, n_tb, n_st;
    int m_a = 0, m_b = 0, m_cnt = 0, m_pc = 0;
    int n_a, n_b, n_cnt, n_pc, n_sel, n_inc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_run = 0; m_s1 = '0; m_s2 = '0; m_prev = 0;
            m_a = 0; m_b = 0; m_cnt = 0; m_pc = 0; m_flags = '0;
        end else begin
            n_act = m_ctrl[31] && m_run;
            n_sel = int'(m_ctrl[13:12]);
            n_raw = n_act && m_s2[n_sel] && !m_prev;
            n_ta  = m_ctrl[11] ? (n_raw && m_a == DA - 1) : n_raw;
            n_a   = !m_ctrl[11] ? 0 : (n_raw ? ((m_a == DA - 1) ? 0 : m_a + 1) : m_a);
            n_tb  = m_ctrl[10] ? (n_ta && m_b == DB - 1) : n_ta;
            n_b   = !m_ctrl[10] ? 0 : (n_ta ? ((m_b == DB - 1) ? 0 : m_b + 1) : m_b);
            n_st  = n_tb && !(m_ctrl[29] && dbg_halt);
            n_inc = (m_cnt + 1) % MOD;
            m_set = '0;
            if (n_st && (n_inc >> LOWB) == int'(m_ctrl[27:16]) && (n_inc % (1 << LOWB)) == 0)
                m_set[0] = 1'b1;
            if (n_st && m_cnt == MOD - 1) m_set[2] = 1'b1;
            if (n_st && m_ctrl[15] && m_pc == int'(m_ctrl[9:0])) m_set[1] = 1'b1;
            n_pc = !m_ctrl[15] ? 0 : (n_st ? ((m_pc == int'(m_ctrl[9:0])) ? 0 : m_pc + 1) : m_pc);
            m_clr   = (wr_en && addr == 2'd1) ? wr_data[2:0] : 3'b0;
            n_flags = (m_flags & ~m_clr) | m_set;
            n_cnt   = n_st ? n_inc : m_cnt;
            n_prev  = n_act ? m_s2[n_sel] : 1'b0;
            n_s2    = n_act ? m_s1 : 4'b0;
            n_s1    = n_act ? src_clk : 4'b0;
            if (!n_act) begin
                n_a = 0; n_b = 0; n_cnt = 0; n_pc = 0; n_flags = '0;
            end
            m_a = n_a; m_b = n_b; m_cnt = n_cnt; m_pc = n_pc; m_flags = n_flags;
            m_prev = n_prev; m_s2 = n_s2; m_s1 = n_s1;
            m_run = m_ctrl[31];
            if (wr_en && addr == 2'd0) m_ctrl = wr_data;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [31:0] m_rd;
    always @(negedge clk) begin
        if (rst_n) begin
            case (addr)
                2'd0:    m_rd = m_ctrl;
                2'd1:    m_rd = {29'b0, m_flags};
                2'd2:    m_rd = 32'(m_cnt);
                default: m_rd = '0;
            endcase
            check("R4 model readback", rd_data, m_rd);
            check("R8 model irq_main", 32'(irq_main),
                  32'((m_flags[0] & m_ctrl[30]) | (m_flags[2] & m_ctrl[28])));
            check("R9 model irq_per", 32'(irq_per), 32'(m_flags[1] & m_ctrl[14]));
        end
    end

    task automatic do_write(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0; addr = 2'd3; wr_data = '0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [31:0] v);
        @(posedge clk); #2;
        addr = a;
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic reconf(input logic [31:0] v);
        do_write(2'd0, 32'h0);
        do_write(2'd0, v);
        repeat (40) @(posedge clk);
    endtask

    task automatic measure(input int n, output int diff);
        logic [31:0] c1, c2;
        read_reg(2'd2, c1);
        repeat (n) @(negedge clk);
        c2 = rd_data;
        diff = int'(c2) - int'(c1);
    endtask

    task automatic set_halt(input logic h);
        @(posedge clk); #2;
        dbg_halt = h;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int d;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // reset state
        read_reg(2'd0, v); check("R1 ctrl after reset", v, 32'h0);
        read_reg(2'd1, v); check("R1 status after reset", v, 32'h0);
        read_reg(2'd2, v); check("R1 count after reset", v, 32'h0);
        check("R1 irqs after reset", {30'b0, irq_main, irq_per}, 32'h0);

        // control readback, disabled hold
        do_write(2'd0, 32'h7ABC_DEF5);
        read_reg(2'd0, v); check("R2 ctrl readback", v, 32'h7ABC_DEF5);
        repeat (50) @(posedge clk);
        read_reg(2'd2, v); check("R3 count held while off", v, 32'h0);
        do_write(2'd0, 32'h4ABC_2DF5);
        repeat (30) @(posedge clk);
        read_reg(2'd2, v); check("R3 count held after select change", v, 32'h0);
        read_reg(2'd1, v); check("R3 flags held while off", v, 32'h0);

        // source selection
        reconf(32'h8000_0000); measure(20, d); check("R4 src0 rate", 32'(d), 32'd10);
        reconf(32'h8000_1000); measure(40, d); check("R4 src1 rate", 32'(d), 32'd10);
        reconf(32'h8000_3000); measure(64, d); check("R4 src3 rate", 32'(d), 32'd4);

        // prescalers
        reconf(32'h8000_0800); measure(160, d); check("R5 div A", 32'(d), 32'd10);
        reconf(32'h8000_0400); measure(80, d);  check("R5 div B", 32'(d), 32'd10);
        reconf(32'h8000_0C00); measure(640, d); check("R5 div A then B", 32'(d), 32'd10);

        // main compare: 5 -> count 20
        reconf(32'hC005_0000);
        repeat (60) @(posedge clk);
        read_reg(2'd1, v); check("R6 main flag set", v, 32'h1);
        check("R8 irq_main with main_ie", 32'(irq_main), 32'h1);
        do_write(2'd1, 32'h6);
        read_reg(2'd1, v); check("R11 zero bits keep flag", v, 32'h1);
        do_write(2'd1, 32'h1);
        read_reg(2'd1, v); check("R11 w1c clears main", v, 32'h0);
        check("R8 irq_main drops", 32'(irq_main), 32'h0);

        // rollover with only rollover interrupt enabled
        reconf(32'h9005_0000);
        repeat (60) @(posedge clk);
        read_reg(2'd1, v); check("R6 main flag again", v, 32'h1);
        check("R8 main flag gated by enable", 32'(irq_main), 32'h0);
        repeat (MOD * 2) @(posedge clk);
        read_reg(2'd1, v); check("R7 rollover flag", v, 32'h5);
        check("R7 rollover irq", 32'(irq_main), 32'h1);
        read_reg(2'd2, v); check("R7 count wrapped low", 32'(v < 32'd200), 32'h1);

        // periodic channel: compare 3
        reconf(32'h8000_C003);
        read_reg(2'd1, v); check("R9 periodic flag", v, 32'h2);
        check("R9 irq_per", 32'(irq_per), 32'h1);
        do_write(2'd1, 32'h2);
        repeat (20) @(posedge clk);
        read_reg(2'd1, v); check("R9 periodic flag returns", v, 32'h2);
        reconf(32'h8000_8003);
        check("R9 irq_per gated", 32'(irq_per), 32'h0);

        // freeze
        reconf(32'hA000_0000);
        set_halt(1'b1); repeat (4) @(posedge clk);
        measure(20, d); check("R10 frozen count", 32'(d), 32'd0);
        set_halt(1'b0); repeat (4) @(posedge clk);
        measure(20, d); check("R10 resume after halt", 32'(d), 32'd10);
        reconf(32'h8000_0000);
        set_halt(1'b1); repeat (4) @(posedge clk);
        measure(20, d); check("R10 no freeze when disabled", 32'(d), 32'd10);
        set_halt(1'b0);

        // disable clears everything
        reconf(32'h8000_C003);
        do_write(2'd0, 32'h0);
        read_reg(2'd2, v); check("R3 count cleared on disable", v, 32'h0);
        read_reg(2'd1, v); check("R3 flags cleared on disable", v, 32'h0);

        repeat (5) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule